// File: doc/BRIEF.md
# Framed Serial Register Access Slave

This block lets an external controller read and write a bank of 12-bit registers across a 10-bit address space over a short serial channel. The controller supplies a serial clock, a frame signal that encloses each transaction, and data on one lane or on four lanes. Each transaction carries a 2-bit command and a 10-bit address, followed by 12 data bits. A write delivers one strobe on the register-file port. A read returns the data, after a one-clock turnaround, on lanes that the block drives itself.

A static strap input selects the lane count. In narrow mode only lane 0 carries data. In wide mode four lanes carry one nibble per clock, so each 12-bit word takes three clocks. The block is clocked by the serial clock itself. It samples inputs on the rising edge and launches read data on the falling edge. A synchronised copy of the active-low reset clears all state.

Top module: `serial_host_slave`

## Requirements
- R1: While reset is applied and after it is released, with no frame active, `ser_oe` is 0 and `reg_we` is 0.
- R2: In narrow mode the word {address, command} is received on lane 0 least significant bit first (command bit 0, command bit 1, address bit 0 through address bit 9), one bit per rising edge, starting at the first rising edge with `ser_frame` high. Command 01 is a write. The 12 data bits follow least significant bit first, and then `reg_addr` and `reg_wdata` present the received values. Lanes 1 to 3 are ignored in narrow mode.
- R3: For a write, `reg_we` is high for exactly one serial clock cycle: the cycle that follows the rising edge capturing the last data bit (edge 24 in narrow mode, edge 6 in wide mode).
- R4: Command 00 is a read. In narrow mode, edge 13 is a turnaround in which the block takes `reg_rdata` for the received address. From the falling edge after edge 13+k, for k = 0 to 11, data bit k is on lane 0 with its enable set. The enable is cleared on the falling edge after edge 25.
- R5: In narrow mode a read enables only lane 0 (`ser_oe` = 0001). In wide mode it enables all four lanes (`ser_oe` = 1111).
- R6: In wide mode (`wide_strap` = 1) the instruction takes three rising edges. Lane i of the first nibble carries bit i of {address[1:0], command[1:0]}, so command bit 0 is on lane 0. The second nibble carries address[5:2] and the third carries address[9:6].
- R7: In wide mode the data moves as the nibbles data[3:0], data[7:4] and data[11:8], with lane 0 holding the lowest bit of each. A write strobes after edge 6. A read uses edge 4 as the turnaround, presents its nibbles for sampling at edges 5, 6 and 7, and releases the lanes after edge 7.
- R8: Commands 10 and 11 are reserved. They produce no `reg_we` and no output enable for the rest of the frame, so a later read returns the register unchanged.
- R9: A low `ser_frame` at any point ends the transaction. A write cut short before its last data bit gives no strobe. A read that is cut short clears `ser_oe` at the next falling edge. The next frame is decoded from its first bit.
- R10: Once a transaction is complete, further clocks with `ser_frame` still high have no effect (no second strobe, no further output enable) until the frame goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk | input | 1 | Serial clock from the controller; clocks the whole block |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_frame | input | 1 | High for the duration of one transaction |
| wide_strap | input | 1 | 0 selects one data lane, 1 selects four lanes |
| ser_din | input | 4 | Data lanes from the controller |
| ser_dout | output | 4 | Read data lanes driven by the block |
| ser_oe | output | 4 | Per-lane output enable for `ser_dout` |
| reg_addr | output | 10 | Register address received in the instruction |
| reg_wdata | output | 12 | Write data received in the data phase |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 12 | Register contents at `reg_addr` |

## Verification
The assertions assume that `wide_strap` changes only while `ser_frame` is low. They also assume that `reg_rdata` is a combinational function of `reg_addr` that is settled by the turnaround edge, and that every input changes away from both clock edges. The bench changes the strap only between frames and models the register bank as an array read directly at `reg_addr`. It drives frame and lanes a quarter period after each rising edge, so both the rising-edge input capture and the falling-edge output launch see stable values.

// File: rtl/shs_pkg.sv
`timescale 1ns/1ps
package shs_pkg;

  typedef enum logic [2:0] {
    ST_INS  = 3'd0,
    ST_WR   = 3'd1,
    ST_TURN = 3'd2,
    ST_RD   = 3'd3,
    ST_DONE = 3'd4
  } shs_state_e;

  localparam int unsigned CMD_W = 2;
  localparam logic [CMD_W-1:0] CMD_READ  = 2'b00;
  localparam logic [CMD_W-1:0] CMD_WRITE = 2'b01;

endpackage

// File: rtl/shs_rx.sv
`timescale 1ns/1ps
module shs_rx #(
  parameter int unsigned INS_W  = 12,
  parameter int unsigned DATA_W = 12,
  parameter int unsigned LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode4,
  input  logic [LANES-1:0]        sdi,
  input  logic                    ins_en,
  input  logic                    dat_en,
  output logic [shs_pkg::CMD_W-1:0] cmd_nxt,
  output logic [INS_W-1:0]        ins_q,
  output logic [DATA_W-1:0]       dat_q
);

  logic [INS_W-1:0]  ins_d;
  logic [DATA_W-1:0] dat_d;

  // Least significant beat first: new beats enter at the top and move down.
  generate
    if (LANES > 1) begin : g_multi
      assign ins_d = mode4 ? {sdi, ins_q[INS_W-1:LANES]}  : {sdi[0], ins_q[INS_W-1:1]};
      assign dat_d = mode4 ? {sdi, dat_q[DATA_W-1:LANES]} : {sdi[0], dat_q[DATA_W-1:1]};
    end else begin : g_single
      logic unused_mode;
      assign unused_mode = mode4;
      assign ins_d = {sdi[0], ins_q[INS_W-1:1]};
      assign dat_d = {sdi[0], dat_q[DATA_W-1:1]};
    end
  endgenerate

  assign cmd_nxt = ins_d[shs_pkg::CMD_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_q <= '0;
    end else if (ins_en) begin
      ins_q <= ins_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
    end else if (dat_en) begin
      dat_q <= dat_d;
    end
  end

endmodule

// File: rtl/shs_ctrl.sv
`timescale 1ns/1ps
module shs_ctrl
  import shs_pkg::*;
#(
  parameter int unsigned INS_W  = 12,
  parameter int unsigned DATA_W = 12,
  parameter int unsigned LANES  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm,
  input  logic             mode4,
  input  logic [CMD_W-1:0] cmd_nxt,
  output logic             ins_en,
  output logic             dat_en,
  output logic             tx_load,
  output logic             tx_shift,
  output logic             rd_active,
  output logic             we
);

  localparam int unsigned MAXB  = (INS_W > DATA_W) ? INS_W : DATA_W;
  localparam int unsigned CNT_W = $clog2(MAXB + 1);
  localparam logic [CNT_W-1:0] IB1_LAST = CNT_W'(INS_W - 1);
  localparam logic [CNT_W-1:0] IB4_LAST = CNT_W'(INS_W / LANES - 1);
  localparam logic [CNT_W-1:0] DB1_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] DB4_LAST = CNT_W'(DATA_W / LANES - 1);

  shs_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             we_q, we_d;
  logic [CNT_W-1:0] ins_last, dat_last;

  assign ins_last = mode4 ? IB4_LAST : IB1_LAST;
  assign dat_last = mode4 ? DB4_LAST : DB1_LAST;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    we_d     = 1'b0;
    ins_en   = 1'b0;
    dat_en   = 1'b0;
    tx_load  = 1'b0;
    tx_shift = 1'b0;
    if (!frm) begin
      st_d  = ST_INS;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_INS: begin
          ins_en = 1'b1;
          if (cnt_q == ins_last) begin
            cnt_d = '0;
            if (cmd_nxt == CMD_WRITE)     st_d = ST_WR;
            else if (cmd_nxt == CMD_READ) st_d = ST_TURN;
            else                          st_d = ST_DONE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_WR: begin
          dat_en = 1'b1;
          if (cnt_q == dat_last) begin
            we_d  = 1'b1;
            st_d  = ST_DONE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_TURN: begin
          tx_load = 1'b1;
          st_d    = ST_RD;
          cnt_d   = '0;
        end
        ST_RD: begin
          tx_shift = 1'b1;
          if (cnt_q == dat_last) begin
            st_d  = ST_DONE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          st_d = ST_DONE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_INS;
      cnt_q <= '0;
      we_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      we_q  <= we_d;
    end
  end

  assign we        = we_q;
  assign rd_active = (st_q == ST_RD);

  // R3: the write strobe never lasts more than one cycle
  p_we_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> !we_q);

  // R9: a strobe only follows an edge on which the frame was still high
  p_we_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> $past(frm));

endmodule

// File: rtl/shs_tx.sv
`timescale 1ns/1ps
module shs_tx #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode4,
  input  logic              frm,
  input  logic              load,
  input  logic              shift,
  input  logic              rd_active,
  input  logic [DATA_W-1:0] rdata,
  output logic [LANES-1:0]  sdo,
  output logic [LANES-1:0]  sdo_oe
);

  logic [DATA_W-1:0] tx_q, tx_d;
  logic [LANES-1:0]  sdo_d, oe_d;

  always_comb begin
    tx_d = tx_q;
    if (load)       tx_d = rdata;
    else if (shift) tx_d = mode4 ? (tx_q >> LANES) : (tx_q >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= '0;
    else        tx_q <= tx_d;
  end

  always_comb begin
    for (int i = 0; i < int'(LANES); i++) begin
      sdo_d[i] = (mode4 || i == 0) ? tx_q[i] : 1'b0;
      oe_d[i]  = rd_active && frm && (mode4 || i == 0);
    end
  end

  // Launch on the falling edge so data is settled at the next rising edge.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo    <= '0;
      sdo_oe <= '0;
    end else begin
      sdo    <= sdo_d;
      sdo_oe <= oe_d;
    end
  end

  // R5: narrow mode never enables more than one lane
  p_narrow_one_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mode4 |-> ($countones(sdo_oe) <= 1));

endmodule

// File: rtl/serial_host_slave.sv
`timescale 1ns/1ps
module serial_host_slave
  import shs_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 12,
  parameter int unsigned LANES  = 4
) (
  input  logic              ser_clk,
  input  logic              rst_n,
  input  logic              ser_frame,
  input  logic              wide_strap,
  input  logic [LANES-1:0]  ser_din,
  output logic [LANES-1:0]  ser_dout,
  output logic [LANES-1:0]  ser_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [DATA_W-1:0] reg_rdata
);

  localparam int unsigned INS_W = CMD_W + ADDR_W;

  logic             rst_m, rst_s;
  logic             ins_en, dat_en, tx_load, tx_shift, rd_active;
  logic [CMD_W-1:0] cmd_nxt;
  logic [INS_W-1:0] ins_q;

  always_ff @(posedge ser_clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  shs_rx #(.INS_W(INS_W), .DATA_W(DATA_W), .LANES(LANES)) i_rx (
    .clk     (ser_clk),
    .rst_n   (rst_s),
    .mode4   (wide_strap),
    .sdi     (ser_din),
    .ins_en  (ins_en),
    .dat_en  (dat_en),
    .cmd_nxt (cmd_nxt),
    .ins_q   (ins_q),
    .dat_q   (reg_wdata)
  );

  shs_ctrl #(.INS_W(INS_W), .DATA_W(DATA_W), .LANES(LANES)) i_ctrl (
    .clk       (ser_clk),
    .rst_n     (rst_s),
    .frm       (ser_frame),
    .mode4     (wide_strap),
    .cmd_nxt   (cmd_nxt),
    .ins_en    (ins_en),
    .dat_en    (dat_en),
    .tx_load   (tx_load),
    .tx_shift  (tx_shift),
    .rd_active (rd_active),
    .we        (reg_we)
  );

  shs_tx #(.DATA_W(DATA_W), .LANES(LANES)) i_tx (
    .clk       (ser_clk),
    .rst_n     (rst_s),
    .mode4     (wide_strap),
    .frm       (ser_frame),
    .load      (tx_load),
    .shift     (tx_shift),
    .rd_active (rd_active),
    .rdata     (reg_rdata),
    .sdo       (ser_dout),
    .sdo_oe    (ser_oe)
  );

  assign reg_addr = ins_q[INS_W-1:CMD_W];

  // R8: a strobe only ever follows a received write command
  p_we_needs_write_r8: assert property (@(posedge ser_clk) disable iff (!rst_s)
    reg_we |-> (ins_q[CMD_W-1:0] == CMD_WRITE));

  // R4: lanes are only driven after a received read command
  p_oe_needs_read_r4: assert property (@(posedge ser_clk) disable iff (!rst_s)
    (ser_oe != '0) |-> (ins_q[CMD_W-1:0] == CMD_READ));

  // R10: strobe and drive never overlap
  p_we_no_drive_r10: assert property (@(posedge ser_clk) disable iff (!rst_s)
    reg_we |-> (ser_oe == '0));

endmodule

// File: tb/test_serial_host_slave.sv
`timescale 1ns/1ps
module test_serial_host_slave;

  localparam int CLK_P = 10;
  localparam int AW = 10;
  localparam int DW = 12;

  logic          ser_clk = 1'b0;
  logic          rst_n;
  logic          ser_frame;
  logic          wide_strap;
  logic [3:0]    ser_din;
  logic [3:0]    ser_dout;
  logic [3:0]    ser_oe;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata;
  logic          reg_we;
  logic [DW-1:0] reg_rdata;

  logic [DW-1:0] mem   [0:(1<<AW)-1];
  logic [DW-1:0] model [0:(1<<AW)-1];

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) ser_clk = ~ser_clk;

  serial_host_slave i_serial_host_slave (
    .ser_clk    (ser_clk),
    .rst_n      (rst_n),
    .ser_frame  (ser_frame),
    .wide_strap (wide_strap),
    .ser_din    (ser_din),
    .ser_dout   (ser_dout),
    .ser_oe     (ser_oe),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_we     (reg_we),
    .reg_rdata  (reg_rdata)
  );

  assign reg_rdata = mem[reg_addr];

  always @(posedge ser_clk) begin
    if (reg_we) mem[reg_addr] <= reg_wdata;
  end

  task automatic check(input bit ok, input string tag, input string what);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  // Drive one frame beat by beat and compare every cycle against the
  // expected outputs worked out from the requirements.
  // flen < 0 means a complete frame (instruction, turnaround slot, data).
  task automatic run_frame(input bit wide, input logic [1:0] cmd,
                           input logic [AW-1:0] addr, input logic [DW-1:0] data,
                           input int flen, input string tag);
    int ib = wide ? 3 : 12;
    int db = wide ? 3 : 12;
    int f  = (flen < 0) ? (ib + 1 + db) : flen;
    int tot = ((f > ib + db + 1) ? f : (ib + db + 1)) + 3;
    logic [11:0] ins = {addr, cmd};
    logic [11:0] rd  = model[addr];
    wide_strap = wide;
    for (int s = 1; s <= tot; s++) begin
      logic [3:0] din;
      bit e_we, e_oe;
      logic [3:0] e_mask, e_dout;
      @(posedge ser_clk);
      #(CLK_P/4);
      ser_frame = (s <= f);
      din = 4'b0000;
      if (s <= ib) begin
        din = wide ? ins[4*(s-1) +: 4] : {3'b101, ins[s-1]};
      end else if (s <= ib + db && cmd == 2'b01) begin
        din = wide ? data[4*(s-ib-1) +: 4] : {3'b010, data[s-ib-1]};
      end else if (s <= ib + db) begin
        din = wide ? 4'b0110 : 4'b1110;
      end
      ser_din = din;
      #(CLK_P/2);
      e_we   = (cmd == 2'b01) && (s == ib + db + 1) && (f >= ib + db);
      e_oe   = (cmd == 2'b00) && (s <= f) && (s >= ib + 2) && (s <= ib + 1 + db);
      e_mask = e_oe ? (wide ? 4'b1111 : 4'b0001) : 4'b0000;
      e_dout = 4'b0000;
      if (e_oe) e_dout = wide ? rd[4*(s-ib-2) +: 4] : {3'b000, rd[s-ib-2]};
      check(reg_we == e_we, tag,
            $sformatf("step %0d reg_we=%b expected %b", s, reg_we, e_we));
      check(ser_oe == e_mask, tag,
            $sformatf("step %0d ser_oe=%b expected %b", s, ser_oe, e_mask));
      if (e_oe)
        check((ser_dout & e_mask) == e_dout, tag,
              $sformatf("step %0d ser_dout=%h expected %h", s, ser_dout & e_mask, e_dout));
      if (e_we)
        check(reg_addr == addr && reg_wdata == data, tag,
              $sformatf("step %0d addr/data=%h/%h expected %h/%h", s, reg_addr, reg_wdata, addr, data));
    end
    if (cmd == 2'b01 && f >= ib + db) model[addr] = data;
  endtask

  initial begin
    #(CLK_P * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) begin
      mem[i]   = DW'(i * 37 + 12'h5a3);
      model[i] = DW'(i * 37 + 12'h5a3);
    end
    rst_n = 1'b0;
    ser_frame = 1'b0;
    wide_strap = 1'b0;
    ser_din = 4'b0000;
    repeat (3) @(posedge ser_clk);
    #(CLK_P/4);
    check(ser_oe == 4'b0000 && reg_we == 1'b0, "R1",
          $sformatf("in reset oe=%b we=%b expected 0000/0", ser_oe, reg_we));
    rst_n = 1'b1;
    repeat (4) @(posedge ser_clk);
    #(CLK_P/4);
    check(ser_oe == 4'b0000 && reg_we == 1'b0, "R1",
          $sformatf("after reset oe=%b we=%b expected 0000/0", ser_oe, reg_we));

    // narrow mode write then read back
    run_frame(1'b0, 2'b01, 10'h2A5, 12'hC3A, -1, "R2 R3");
    run_frame(1'b0, 2'b00, 10'h2A5, 12'h000, -1, "R4 R5");
    // wide mode write then read back
    run_frame(1'b1, 2'b01, 10'h13C, 12'h5E1, -1, "R6 R7 R3");
    run_frame(1'b1, 2'b00, 10'h13C, 12'h000, -1, "R6 R7 R5");
    // cross-mode: read in wide mode what narrow mode wrote and vice versa
    run_frame(1'b1, 2'b00, 10'h2A5, 12'h000, -1, "R7 R2");
    run_frame(1'b0, 2'b00, 10'h13C, 12'h000, -1, "R4 R6");
    // address and data extremes
    run_frame(1'b1, 2'b01, 10'h3FF, 12'hFFF, -1, "R6 R7");
    run_frame(1'b0, 2'b01, 10'h000, 12'h000, -1, "R2");
    run_frame(1'b0, 2'b00, 10'h3FF, 12'h000, -1, "R4");
    run_frame(1'b1, 2'b00, 10'h000, 12'h000, -1, "R7");
    // reserved commands leave registers alone
    run_frame(1'b0, 2'b10, 10'h2A5, 12'h111, -1, "R8");
    run_frame(1'b1, 2'b11, 10'h13C, 12'h222, -1, "R8");
    run_frame(1'b0, 2'b00, 10'h2A5, 12'h000, -1, "R8");
    run_frame(1'b1, 2'b00, 10'h13C, 12'h000, -1, "R8");
    // aborted write one bit short, aborted read mid data, aborted instruction
    run_frame(1'b0, 2'b01, 10'h2A5, 12'h777, 23, "R9");
    run_frame(1'b1, 2'b01, 10'h13C, 12'h888, 5, "R9");
    run_frame(1'b0, 2'b00, 10'h2A5, 12'h000, 17, "R9");
    run_frame(1'b1, 2'b00, 10'h13C, 12'h000, 5, "R9");
    run_frame(1'b0, 2'b01, 10'h0F0, 12'h999, 6, "R9");
    run_frame(1'b0, 2'b00, 10'h2A5, 12'h000, -1, "R9");
    run_frame(1'b1, 2'b00, 10'h13C, 12'h000, -1, "R9");
    run_frame(1'b0, 2'b00, 10'h0F0, 12'h000, -1, "R9");
    // extra clocks after completion are ignored
    run_frame(1'b0, 2'b01, 10'h155, 12'hABC, 31, "R10");
    run_frame(1'b1, 2'b00, 10'h155, 12'h000, 14, "R10");
    run_frame(1'b1, 2'b01, 10'h2AA, 12'h123, 12, "R10");
    run_frame(1'b0, 2'b00, 10'h2AA, 12'h000, 30, "R10");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule